// File: doc/BRIEF.md
# Extended Reed-Solomon Block Encoder over GF(128)

This block turns a stream of 7-bit message symbols into blocks of an extended, systematic Reed-Solomon code. Each block holds 122 information symbols and is sent as 128 symbols. A producer offers symbols with a valid/ready handshake and raises a start marker on the first symbol of each block. The encoder copies every accepted symbol to its output one cycle later. After the last information symbol it stops taking input and emits five parity symbols. It then emits a sixth check symbol, which extends the code.

The parity comes from a division shift register. The message, shifted up by five places, is divided by a degree-5 generator whose roots are the first five powers of the field's primitive element. The extra symbol is the 127-symbol codeword evaluated at the sixth power of that element. A Horner accumulator computes it while the codeword streams out. The code corrects up to three symbol errors per block.

Top module: `rse_encoder`

## Requirements
- R1: Arithmetic is in GF(2^7) built from x^7 + x^3 + 1. Bit k of a symbol is the coefficient of alpha^k, so alpha is 7'h02. The parity symbols equal the remainder of m(X)·X^5 divided by g(X) = X^5 + a^52·X^4 + a^116·X^3 + a^119·X^2 + a^61·X + a^15.
- R2: Each information symbol accepted within a block appears on out_data one cycle after acceptance, with out_valid high and out_last low, in the order it was accepted (m121 first, m0 last).
- R3: The first 127 output symbols of a block form a codeword that evaluates to zero at alpha^1 through alpha^5. The first symbol sent is the coefficient of X^126. Parity is sent r4 first and r0 last.
- R4: The 128th output symbol equals the 127-symbol codeword evaluated at alpha^6. out_last is high with this symbol and with no other.
- R5: in_ready is low for exactly six cycles, starting the cycle after m0 is accepted. The five parity symbols and the extension symbol leave on those six consecutive cycles.
- R6: A symbol accepted with in_start high always begins a new block as m121. This holds even in the middle of a block, and the parity and extension state restart from zero.
- R7: A symbol accepted with in_start low while no block is open is dropped and produces no output.
- R8: Cycles with in_valid low produce no output and do not disturb the parity or extension of the block in progress.
- R9: During reset, out_valid and out_last are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input symbol offered |
| in_start | input | 1 | Offered symbol is the first of a block |
| in_data | input | 7 | Input message symbol |
| in_ready | output | 1 | Encoder accepts a symbol this cycle |
| out_valid | output | 1 | out_data holds a code symbol |
| out_data | output | 7 | Output code symbol |
| out_last | output | 1 | Output symbol is the extension symbol, closing the block |

## Verification
The case hardest to reach from the ports is a producer that already holds the next block's first symbol while the encoder is still emitting parity. The stimulus runs blocks back to back: the next start symbol is driven in the cycle right after m0. The bench counts how long it waits before that symbol is taken. A restart in the middle of a block is also hard to reach. It is forced by abandoning a partly sent block with a fresh start symbol, and the bench then checks the syndromes of the block that follows.

// File: rtl/rse_pkg.sv
// Shared constants, types and GF(2^7) arithmetic for the extended RS encoder.
// Assumes the field polynomial x^7 + x^3 + 1 and consecutive generator roots.
package rse_pkg;
    localparam int SYM_W      = 7;
    localparam int MSG_LEN    = 122;
    localparam int NPAR       = 5;
    localparam int FIRST_ROOT = 1;
    localparam int EXT_POW    = FIRST_ROOT + NPAR;
    localparam int IDX_W      = $clog2(MSG_LEN);
    localparam int PCNT_W     = $clog2(NPAR + 1);

    typedef logic [SYM_W-1:0] sym_t;

    // Reduction term for x^7 = x^3 + 1
    localparam sym_t RED = sym_t'(7'h09);

    typedef enum logic [1:0] {PH_IDLE, PH_MSG, PH_PAR} phase_t;

    // Multiply by alpha
    function automatic sym_t gf_xtime(sym_t a);
        return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? RED : '0);
    endfunction

    // General field product
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t p = '0;
        sym_t s = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) p = p ^ s;
            s = gf_xtime(s);
        end
        return p;
    endfunction

    // alpha raised to n
    function automatic sym_t gf_pow(int n);
        sym_t r = sym_t'(1);
        for (int i = 0; i < n; i++) r = gf_xtime(r);
        return r;
    endfunction

    // Coefficient of X^k in the product of (X + alpha^j) over the generator roots
    function automatic sym_t gen_coef(int k);
        sym_t c [0:NPAR];
        sym_t root;
        for (int i = 0; i <= NPAR; i++) c[i] = '0;
        c[0] = sym_t'(1);
        for (int j = 0; j < NPAR; j++) begin
            root = gf_pow(FIRST_ROOT + j);
            for (int i = NPAR; i > 0; i--) c[i] = c[i-1] ^ gf_mul(c[i], root);
            c[0] = gf_mul(c[0], root);
        end
        return c[k];
    endfunction
endpackage

// File: rtl/rse_cmul.sv
// Constant multiplier in GF(2^7): y = a * K.
// Built as an XOR matrix whose columns are K * alpha^i, fixed at elaboration.
module rse_cmul import rse_pkg::*; #(
    parameter sym_t K = sym_t'(1)
) (
    input  sym_t a,
    output sym_t y
);
    sym_t part [SYM_W];

    for (genvar i = 0; i < SYM_W; i++) begin : g_col
        localparam sym_t COL = gf_mul(K, sym_t'(1) << i);
        assign part[i] = a[i] ? COL : '0;
    end

    // Sum of the selected columns
    always_comb begin
        y = '0;
        for (int i = 0; i < SYM_W; i++) y = y ^ part[i];
    end
endmodule

// File: rtl/rse_divider.sv
// Division shift register for the systematic parity.
// On step_msg it absorbs one message symbol; clr treats the register as zero.
// On step_out it shifts toward the top and fills with zero, presenting r4..r0.
// Assumes step_msg and step_out are never high together.
module rse_divider import rse_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step_msg,
    input  logic step_out,
    input  sym_t din,
    output sym_t rem_hi,
    output logic empty
);
    sym_t rem  [NPAR];
    sym_t base [NPAR];
    sym_t tap  [NPAR];
    sym_t nxt  [NPAR];
    sym_t fb;

    // Register view for this step, zeroed at block start
    always_comb begin
        for (int i = 0; i < NPAR; i++) base[i] = clr ? '0 : rem[i];
    end

    assign fb = din ^ base[NPAR-1];

    for (genvar i = 0; i < NPAR; i++) begin : g_tap
        rse_cmul #(.K(gen_coef(i))) u_tap (.a(fb), .y(tap[i]));
    end

    // Next remainder after absorbing one symbol
    always_comb begin
        nxt[0] = tap[0];
        for (int i = 1; i < NPAR; i++) nxt[i] = base[i-1] ^ tap[i];
    end

    // Remainder register: absorb, drain or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPAR; i++) rem[i] <= '0;
        end else if (step_msg) begin
            for (int i = 0; i < NPAR; i++) rem[i] <= nxt[i];
        end else if (step_out) begin
            rem[0] <= '0;
            for (int i = 1; i < NPAR; i++) rem[i] <= rem[i-1];
        end
    end

    assign rem_hi = rem[NPAR-1];

    // Drained flag
    always_comb begin
        empty = 1'b1;
        for (int i = 0; i < NPAR; i++) if (rem[i] != '0) empty = 1'b0;
    end

    a_r3_one_step_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_msg && step_out));
endmodule

// File: rtl/rse_horner.sv
// Evaluates the streaming codeword at alpha^EXT_POW by Horner's rule:
// acc = acc * alpha^EXT_POW + symbol for every message and parity symbol.
// clr with step starts a fresh evaluation from the given symbol.
module rse_horner import rse_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  sym_t din,
    output sym_t acc
);
    sym_t src;
    sym_t prod;

    assign src = clr ? '0 : acc;

    rse_cmul #(.K(gf_pow(EXT_POW))) u_pt (.a(src), .y(prod));

    // Accumulator update
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (step) acc <= prod ^ din;
    end

    a_r6_clear_seeds: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && step) |=> (acc == $past(din)));
endmodule

// File: rtl/rse_ctrl.sv
// Block sequencer: counts the information symbols, then runs the six
// output-only cycles (five parity, one extension) with input held off.
// A start-marked symbol always opens a new block; unmarked symbols
// arriving while no block is open are dropped.
module rse_ctrl import rse_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_start,
    output logic in_ready,
    output logic take,
    output logic clr,
    output logic par_step,
    output logic ext_step,
    output logic in_block
);
    phase_t              phase;
    logic [IDX_W-1:0]    idx;
    logic [IDX_W-1:0]    idx_eff;
    logic [PCNT_W-1:0]   pcnt;
    logic                hs;
    logic                last_msg;

    assign in_ready = (phase != PH_PAR);
    assign hs       = in_valid && in_ready;
    assign take     = hs && (in_start || phase == PH_MSG);
    assign clr      = hs && in_start;
    assign idx_eff  = in_start ? '0 : idx;
    assign last_msg = take && (idx_eff == IDX_W'(MSG_LEN - 1));
    assign par_step = (phase == PH_PAR) && (pcnt < PCNT_W'(NPAR));
    assign ext_step = (phase == PH_PAR) && (pcnt == PCNT_W'(NPAR));
    assign in_block = (phase == PH_MSG);

    // Phase, symbol index and output-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            idx   <= '0;
            pcnt  <= '0;
        end else begin
            case (phase)
                PH_IDLE, PH_MSG: begin
                    if (take) begin
                        if (last_msg) begin
                            phase <= PH_PAR;
                            pcnt  <= '0;
                        end else begin
                            phase <= PH_MSG;
                            idx   <= idx_eff + 1'b1;
                        end
                    end
                end
                PH_PAR: begin
                    if (ext_step) begin
                        phase <= PH_IDLE;
                        pcnt  <= '0;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    a_r5_six_held: assert property (@(posedge clk) disable iff (!rst_n)
        last_msg |=> !in_ready ##1 !in_ready ##1 !in_ready ##1 !in_ready
                     ##1 !in_ready ##1 !in_ready ##1 in_ready);

    a_r6_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !last_msg) |=> in_block);
endmodule

// File: rtl/rse_encoder.sv
// Extended systematic RS encoder, 122 information + 6 check symbols of 7 bits.
// Input symbols are echoed one cycle after acceptance; then r4..r0 and the
// evaluation at alpha^6 follow on six consecutive cycles. The output has no
// backpressure; the consumer must take every valid symbol.
module rse_encoder import rse_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic [SYM_W-1:0] in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_data,
    output logic             out_last
);
    logic take, clr, par_step, ext_step, in_block, div_empty;
    sym_t rem_hi, ev_acc, ev_din;

    rse_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_ready(in_ready), .take(take), .clr(clr), .par_step(par_step),
        .ext_step(ext_step), .in_block(in_block)
    );

    rse_divider u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step_msg(take),
        .step_out(par_step), .din(in_data), .rem_hi(rem_hi), .empty(div_empty)
    );

    assign ev_din = take ? in_data : rem_hi;

    rse_horner u_ev (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(take | par_step),
        .din(ev_din), .acc(ev_acc)
    );

    // Output register: echo, parity or extension symbol
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= take | par_step | ext_step;
            out_last  <= ext_step;
            if (take)          out_data <= in_data;
            else if (par_step) out_data <= rem_hi;
            else if (ext_step) out_data <= ev_acc;
        end
    end

    a_r2_echo: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (out_valid && !out_last && out_data == $past(in_data)));

    a_r4_last_drained: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> div_empty);

    a_r4_last_reopens: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (in_ready && out_valid));

    a_r7_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_start && !in_block) |=> !out_valid);
endmodule

// File: tb/sim_rse_encoder.sv
// Self-checking bench: sweeps symbol values and impulse positions, runs
// back-to-back and gapped blocks, a mid-block restart and dropped symbols.
module sim_rse_encoder;
    localparam int K = 122;
    localparam int N = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_start = 1'b0;
    logic [6:0] in_data = '0;
    logic       in_ready, out_valid, out_last;
    logic [6:0] out_data;

    always #4 clk = ~clk;

    rse_encoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last)
    );

    int checks = 0;
    int errors = 0;
    int mon_cnt = 0;
    int blocks_done = 0;
    int total_out = 0;
    int drv_blk = 0;
    int cyc = 0;
    int prev_cyc = 0;
    bit par_gap = 0;
    bit last_bad = 0;
    logic [6:0] exp_msg [0:1][0:K-1];
    logic [6:0] rx [0:N-1];

    function automatic logic [6:0] bmul(logic [6:0] a, logic [6:0] b);
        logic [6:0] p = '0;
        logic [6:0] s = a;
        for (int i = 0; i < 7; i++) begin
            if (b[i]) p = p ^ s;
            s = s[6] ? ({s[5:0], 1'b0} ^ 7'h09) : {s[5:0], 1'b0};
        end
        return p;
    endfunction

    function automatic logic [6:0] bpow(int n);
        logic [6:0] r = 7'h01;
        for (int i = 0; i < n; i++) r = bmul(r, 7'h02);
        return r;
    endfunction

    function automatic logic [6:0] eval_at(int j);
        logic [6:0] a = bpow(j);
        logic [6:0] s = '0;
        for (int i = 0; i < N - 1; i++) s = bmul(s, a) ^ rx[i];
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Checks one completed output block against the requirements
    task automatic check_block();
        int slot = blocks_done % 2;
        int e0 = errors;
        int bad_i = -1;
        logic [6:0] g [1:5];
        logic [6:0] r [0:4];
        logic [6:0] f;
        check(mon_cnt == N - 1, "R4 block length with out_last", mon_cnt + 1, N);
        for (int i = 0; i < K; i++)
            if (bad_i < 0 && rx[i] != exp_msg[slot][i]) bad_i = i;
        check(bad_i < 0, "R2 message echo first mismatch index", bad_i, -1);
        for (int j = 1; j <= 5; j++)
            check(eval_at(j) == 7'h00, $sformatf("R3 syndrome at alpha^%0d", j), eval_at(j), 0);
        check(rx[N-1] == eval_at(6), "R4 extension symbol", rx[N-1], eval_at(6));
        g[1] = bpow(52); g[2] = bpow(116); g[3] = bpow(119); g[4] = bpow(61); g[5] = bpow(15);
        for (int i = 0; i < 5; i++) r[i] = '0;
        for (int i = 0; i < K; i++) begin
            f = exp_msg[slot][i] ^ r[0];
            for (int k = 0; k < 4; k++) r[k] = r[k+1] ^ bmul(f, g[k+1]);
            r[4] = bmul(f, g[5]);
        end
        for (int k = 0; k < 5; k++)
            check(rx[K+k] == r[k], $sformatf("R1 parity r%0d", 4 - k), rx[K+k], r[k]);
        check(!par_gap, "R5 check symbols on consecutive cycles", par_gap, 0);
        last_bad = (errors != e0);
    endtask

    // Output monitor, sampling away from the clock edge
    always @(posedge clk) begin
        #2;
        cyc++;
        if (rst_n && out_valid) begin
            total_out++;
            if (mon_cnt >= K && cyc != prev_cyc + 1) par_gap = 1'b1;
            prev_cyc = cyc;
            if (mon_cnt < N) rx[mon_cnt] = out_data;
            if (out_last) begin
                check_block();
                blocks_done++;
                mon_cnt = 0;
                par_gap = 1'b0;
            end else begin
                mon_cnt++;
            end
        end
    end

    task automatic push(input logic [6:0] d, input bit st, output int waited);
        in_valid = 1'b1;
        in_data = d;
        in_start = st;
        waited = 0;
        while (!in_ready) begin
            @(negedge clk);
            waited++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
    endtask

    function automatic logic [6:0] msg_sym(int mode, int i, int arg);
        case (mode)
            0:       return 7'(arg);
            1:       return (i == arg) ? 7'h5A : 7'h00;
            2:       return 7'(i * 37 + arg * 11 + i * i);
            default: return 7'(i + arg);
        endcase
    endfunction

    task automatic send_block(input int mode, input int arg, input int gap, output int first_wait);
        int slot = drv_blk % 2;
        int w;
        for (int i = 0; i < K; i++) exp_msg[slot][i] = msg_sym(mode, i, arg);
        first_wait = 0;
        for (int i = 0; i < K; i++) begin
            push(exp_msg[slot][i], i == 0, w);
            if (i == 0) first_wait = w;
            if (gap > 0 && (i % gap) == gap - 1) repeat (1 + i % 3) @(negedge clk);
        end
        drv_blk++;
    endtask

    task automatic wait_done();
        while (blocks_done < drv_blk) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int w;
        int e0;
        // R9: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
        check(out_last == 1'b0, "R9 out_last in reset", out_last, 0);
        check(in_ready == 1'b1, "R9 in_ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: unmarked symbols with no open block are dropped
        for (int i = 0; i < 5; i++) push(7'(i + 3), 1'b0, w);
        repeat (3) @(negedge clk);
        check(total_out == 0, "R7 dropped symbols produced output", total_out, 0);

        // Value sweep, back to back; R5 wait seen by the next start symbol
        for (int v = 0; v < 128; v++) begin
            send_block(0, v, 0, w);
            if (v > 0) check(w == 6, "R5 input held off after m0", w, 6);
        end
        wait_done();

        // Impulse position sweep
        for (int p = 0; p < K; p++) send_block(1, p, 0, w);
        wait_done();

        // R8: gapped input
        e0 = errors;
        for (int s = 0; s < 8; s++) send_block(2, s, 3 + s, w);
        wait_done();
        check(errors == e0, "R8 gapped blocks intact", errors - e0, 0);

        // R6: abandon a block partway through, then restart
        for (int i = 0; i < 10; i++) push(7'(7 * i + 1), i == 0, w);
        @(negedge clk);
        check(mon_cnt == 10, "R6 partial block echoed", mon_cnt, 10);
        mon_cnt = 0;
        send_block(3, 5, 0, w);
        wait_done();
        check(!last_bad, "R6 restarted block is a valid codeword", last_bad, 0);

        // R4: exactly one out_last per block
        check(blocks_done == drv_blk, "R4 block count", blocks_done, drv_blk);
        check(total_out == drv_blk * N + 10, "R4 total output symbols", total_out, drv_blk * N + 10);
        finish_run();
    end
endmodule